// File: doc/BRIEF.md
# Source-to-Target Address Mapping Engine

This block runs beside an instruction translator that converts 32-bit MIPS code into RV32I code. It reads the source program one word per cycle and does not stall. For each word it predicts how many target instructions the translator will emit. A running target program counter advances by four bytes per predicted instruction. Before each advance, the current value is stored in a mapping table at a slot derived from the source address. Because the block never waits, it finishes well ahead of the translator.

The translator uses a lookup port to find where a branch destination lands in the target code. It presents the destination's source PC and the target PC of its own branch instruction. It holds the request until the block signals ready. Ready is granted only when the requested slot has been written since the last start. One cycle after acceptance the block returns the mapped target PC and the retargeted branch offset.

The expansion prediction covers four cases. It adds instructions for immediates that do not fit a signed 12-bit field. It adds spill and fill instructions for operands held in registers set aside for reallocation. It replaces indirect jumps with a fixed three-instruction trap sequence. Any opcode it does not recognise is treated the same way.

Top module: `amap_engine`

## Requirements
- R1: After reset, `busy`, `fetch_en`, `q_ready` and `q_valid` are all low.
- R2: A `start` pulse begins a scan. From the next cycle, `fetch_en` is asserted for exactly `src_len` consecutive cycles, with `fetch_idx` running 0, 1, 2 and so on. The word for index k is expected on `fetch_word` one cycle after it is requested. `busy` falls once the last word is absorbed. A length of zero fetches nothing.
- R3: Table entry k holds `tpc_base` plus 4 times the sum of the expansion counts of source words 0 to k-1. After the scan, `tpc_next` equals `tpc_base` plus 4 times the total count.
- R4: The base expansion count is 3 for each of these: opcode 0 with funct 8 or 9 (register jumps), opcode 0 with any funct outside {0,2,3,4,6,7,0x20–0x27,0x2A,0x2B}, and any opcode not listed in R4–R6. The base count is 1 for each of these: recognised opcode-0 words, opcodes 1, 4, 5, 6 and 7 (branches), 2 and 3 (jumps), and 15 (upper immediate).
- R5: Opcodes 8–11 sign-extend bits 15:0, and opcodes 12–14 zero-extend them. If the extended value lies outside −2048..2047, the count gains 1 when its bits 11:0 are zero and 2 otherwise.
- R6: Loads (opcodes 0x20, 0x21, 0x23, 0x24, 0x25) and stores (0x28, 0x29, 0x2B) gain 2 when their sign-extended offset lies outside −2048..2047.
- R7: Bit r of `realloc_mask` marks register r (r≠0) as reallocated. The count gains 1 for each distinct reallocated source register and 1 for a reallocated destination. Register fields are rs = bits 25:21, rt = bits 20:16 and rd = bits 15:11. Sources are:
  - opcode 0: rt for funct 0, 2 and 3, and rs and rt otherwise;
  - branches 4 and 5: rs and rt;
  - branches 1, 6 and 7: rs;
  - immediates and loads: rs;
  - stores: rs and rt.

  The destination is rd for opcode 0 and rt for immediates, loads and opcode 15. Words that take the fixed base count of 3, and the jump opcodes 2 and 3, gain nothing.
- R8: A lookup addresses slot ((`q_spc` − `spc_base`) >> 2) mod 4096. `q_ready` is high only while `q_req` is high and that slot has been written since the most recent `start`. A `start` makes every slot not ready.
- R9: A lookup is accepted in a cycle where `q_ready` is high. The next cycle asserts `q_valid` for one cycle with `q_tpc` set to the entry value and `q_offset` = `q_tpc` − `q_branch_tpc`.
- R10: A lookup issued mid-scan for a slot not yet written stalls with `q_ready` low. It is granted once the slot is written and then returns the correct value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a new scan and clears table validity |
| spc_base | input | 32 | Source address of source word 0 |
| tpc_base | input | 32 | Target address assigned to source word 0 |
| src_len | input | 13 | Number of source words to scan |
| realloc_mask | input | 32 | One bit per register marked for reallocation |
| fetch_en | output | 1 | Source word request |
| fetch_idx | output | 12 | Index of the requested source word |
| fetch_word | input | 32 | Source word, one cycle after the request |
| busy | output | 1 | Scan in progress |
| tpc_next | output | 32 | Running target PC |
| q_req | input | 1 | Lookup request, held until accepted |
| q_spc | input | 32 | Source address being looked up |
| q_branch_tpc | input | 32 | Target PC of the requesting branch |
| q_ready | output | 1 | Lookup slot written; request accepted this cycle |
| q_valid | output | 1 | Lookup result valid |
| q_tpc | output | 32 | Mapped target PC |
| q_offset | output | 32 | Mapped target PC minus requesting branch PC |

## Verification
The bound checker checks the following on every cycle:
- consecutive fetches step the index by one and restart at zero after `start`;
- a lookup answer appears exactly one cycle after acceptance;
- a start blocks lookups in the cycle after it;
- the running target PC is steady while idle.

The stored target addresses, and so the expansion counts, can only be shown by the bench's scenarios. These cover a directed program of boundary immediates and reallocation patterns, randomized sweeps over many register masks, a zero-length scan, and an out-of-range and a mid-scan lookup.

// File: rtl/amap_pkg.sv
package amap_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = 3;

    typedef struct packed {
        logic [CNT_W-1:0] base;
        logic             src_a;
        logic             src_b;
        logic             dst_en;
        logic [4:0]       ra;
        logic [4:0]       rb;
        logic [4:0]       rd;
    } xlat_info_t;

    function automatic logic fits12(input logic [WORD_W-1:0] v);
        return (v[WORD_W-1:11] == '0) || (v[WORD_W-1:11] == '1);
    endfunction

    function automatic logic [CNT_W-1:0] unfold_extra(input logic [WORD_W-1:0] v);
        if (fits12(v))            return 3'd0;
        else if (v[11:0] == '0)   return 3'd1;
        else                      return 3'd2;
    endfunction

    function automatic xlat_info_t classify(input logic [WORD_W-1:0] w);
        xlat_info_t       i;
        logic [5:0]       op;
        logic [5:0]       fn;
        logic [WORD_W-1:0] sx;
        logic [WORD_W-1:0] zx;
        op = w[31:26];
        fn = w[5:0];
        sx = {{16{w[15]}}, w[15:0]};
        zx = {16'b0, w[15:0]};
        i = '0;
        i.base = 3'd3;
        i.ra = w[25:21];
        i.rb = w[20:16];
        i.rd = w[20:16];
        case (op)
            6'h00: begin
                i.rd = w[15:11];
                case (fn)
                    6'h00, 6'h02, 6'h03: begin
                        i.base = 3'd1; i.src_b = 1'b1; i.dst_en = 1'b1;
                    end
                    6'h04, 6'h06, 6'h07, 6'h20, 6'h21, 6'h22, 6'h23,
                    6'h24, 6'h25, 6'h26, 6'h27, 6'h2a, 6'h2b: begin
                        i.base = 3'd1; i.src_a = 1'b1; i.src_b = 1'b1; i.dst_en = 1'b1;
                    end
                    default: i.base = 3'd3;
                endcase
            end
            6'h01, 6'h06, 6'h07: begin i.base = 3'd1; i.src_a = 1'b1; end
            6'h04, 6'h05:        begin i.base = 3'd1; i.src_a = 1'b1; i.src_b = 1'b1; end
            6'h02, 6'h03:        i.base = 3'd1;
            6'h08, 6'h09, 6'h0a, 6'h0b: begin
                i.base = 3'd1 + unfold_extra(sx); i.src_a = 1'b1; i.dst_en = 1'b1;
            end
            6'h0c, 6'h0d, 6'h0e: begin
                i.base = 3'd1 + unfold_extra(zx); i.src_a = 1'b1; i.dst_en = 1'b1;
            end
            6'h0f: begin i.base = 3'd1; i.dst_en = 1'b1; end
            6'h20, 6'h21, 6'h23, 6'h24, 6'h25: begin
                i.base = fits12(sx) ? 3'd1 : 3'd3; i.src_a = 1'b1; i.dst_en = 1'b1;
            end
            6'h28, 6'h29, 6'h2b: begin
                i.base = fits12(sx) ? 3'd1 : 3'd3; i.src_a = 1'b1; i.src_b = 1'b1;
            end
            default: i.base = 3'd3;
        endcase
        return i;
    endfunction

endpackage

// File: rtl/amap_count.sv
module amap_count
    import amap_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [WORD_W-1:0] mask,
    output logic [CNT_W-1:0]  count
);
    xlat_info_t info;
    logic       fill_a;
    logic       fill_b;
    logic       spill_d;

    always_comb begin
        info    = classify(word);
        fill_a  = info.src_a && (info.ra != 5'd0) && mask[info.ra];
        fill_b  = info.src_b && (info.rb != 5'd0) && mask[info.rb]
                  && !(info.src_a && (info.ra == info.rb));
        spill_d = info.dst_en && (info.rd != 5'd0) && mask[info.rd];
        count   = info.base + CNT_W'(fill_a) + CNT_W'(fill_b) + CNT_W'(spill_d);
    end
endmodule

// File: rtl/amap_scan.sv
module amap_scan
    import amap_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IDX_W:0]    src_len,
    input  logic [WORD_W-1:0] tpc_base,
    input  logic [CNT_W-1:0]  count,
    output logic              fetch_en,
    output logic [IDX_W-1:0]  fetch_idx,
    output logic              busy,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [WORD_W-1:0] wr_data
);
    localparam int LEN_W = IDX_W + 1;

    logic [LEN_W-1:0]  f_cnt;
    logic              running;
    logic              d_valid;
    logic [IDX_W-1:0]  d_idx;
    logic [WORD_W-1:0] acc;

    assign fetch_en  = running && (f_cnt < src_len);
    assign fetch_idx = f_cnt[IDX_W-1:0];
    assign busy      = running;
    assign wr_en     = d_valid;
    assign wr_idx    = d_idx;
    assign wr_data   = acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            f_cnt   <= '0;
            d_valid <= 1'b0;
            d_idx   <= '0;
            acc     <= '0;
        end else if (start) begin
            running <= 1'b1;
            f_cnt   <= '0;
            d_valid <= 1'b0;
            acc     <= tpc_base;
        end else begin
            d_valid <= fetch_en;
            d_idx   <= fetch_idx;
            if (fetch_en)
                f_cnt <= f_cnt + 1'b1;
            if (d_valid)
                acc <= acc + {{(WORD_W-CNT_W-2){1'b0}}, count, 2'b00};
            if (running && !fetch_en && !d_valid)
                running <= 1'b0;
        end
    end
endmodule

// File: rtl/amap_table.sv
module amap_table
    import amap_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_req,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WORD_W-1:0] rd_self,
    output logic              rd_ready,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] rd_self_q
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int MARK_W = IDX_W + 1;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [MARK_W-1:0] mark;

    assign rd_ready = rd_req && ({1'b0, rd_idx} < mark);

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_idx] <= wr_data;
        if (rd_ready) begin
            rd_data   <= mem[rd_idx];
            rd_self_q <= rd_self;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            mark <= '0;
        else if (wr_en)
            mark <= {1'b0, wr_idx} + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_valid <= 1'b0;
        else
            rd_valid <= rd_ready;
    end
endmodule

// File: rtl/amap_engine.sv
module amap_engine
    import amap_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [31:0]       spc_base,
    input  logic [31:0]       tpc_base,
    input  logic [IDX_W:0]    src_len,
    input  logic [31:0]       realloc_mask,
    output logic              fetch_en,
    output logic [IDX_W-1:0]  fetch_idx,
    input  logic [31:0]       fetch_word,
    output logic              busy,
    output logic [31:0]       tpc_next,
    input  logic              q_req,
    input  logic [31:0]       q_spc,
    input  logic [31:0]       q_branch_tpc,
    output logic              q_ready,
    output logic              q_valid,
    output logic [31:0]       q_tpc,
    output logic [31:0]       q_offset
);
    logic [CNT_W-1:0]  count;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [WORD_W-1:0] wr_data;
    logic [WORD_W-1:0] q_delta;
    logic [WORD_W-1:0] self_q;

    assign q_delta  = q_spc - spc_base;
    assign tpc_next = wr_data;
    assign q_offset = q_tpc - self_q;

    amap_count u_count (
        .word  (fetch_word),
        .mask  (realloc_mask),
        .count (count)
    );

    amap_scan #(.IDX_W(IDX_W)) u_scan (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .src_len   (src_len),
        .tpc_base  (tpc_base),
        .count     (count),
        .fetch_en  (fetch_en),
        .fetch_idx (fetch_idx),
        .busy      (busy),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    amap_table #(.IDX_W(IDX_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .clr       (start),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_req    (q_req),
        .rd_idx    (q_delta[IDX_W+1:2]),
        .rd_self   (q_branch_tpc),
        .rd_ready  (q_ready),
        .rd_valid  (q_valid),
        .rd_data   (q_tpc),
        .rd_self_q (self_q)
    );
endmodule

// File: rtl/amap_engine_chk.sv
module amap_engine_chk #(
    parameter int IDX_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             fetch_en,
    input logic [IDX_W-1:0] fetch_idx,
    input logic             busy,
    input logic [31:0]      tpc_next,
    input logic             q_req,
    input logic             q_ready,
    input logic             q_valid
);
    assert_fetch_step_R2: assert property (@(posedge clk) disable iff (rst)
        (fetch_en && $past(fetch_en) && !$past(start)) |-> (fetch_idx == $past(fetch_idx) + 1'b1));

    assert_fetch_restart_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> (!fetch_en || fetch_idx == '0));

    assert_fetch_only_busy_R2: assert property (@(posedge clk) disable iff (rst)
        fetch_en |-> busy);

    assert_idle_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start && !$past(busy) && !$past(start)) |-> $stable(tpc_next));

    assert_start_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        start |=> !q_ready);

    assert_answer_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
        (q_req && q_ready) |=> q_valid);

    assert_answer_has_cause_R9: assert property (@(posedge clk) disable iff (rst)
        q_valid |-> $past(q_req && q_ready));
endmodule

bind amap_engine amap_engine_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .fetch_en  (fetch_en),
    .fetch_idx (fetch_idx),
    .busy      (busy),
    .tpc_next  (tpc_next),
    .q_req     (q_req),
    .q_ready   (q_ready),
    .q_valid   (q_valid)
);

// File: tb/tb_amap_engine.sv
module tb_amap_engine;
    localparam int CLK_P = 10;
    localparam int IDX_W = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [31:0]       spc_base = '0;
    logic [31:0]       tpc_base = '0;
    logic [IDX_W:0]    src_len = '0;
    logic [31:0]       realloc_mask = '0;
    logic              fetch_en;
    logic [IDX_W-1:0]  fetch_idx;
    logic [31:0]       fetch_word = '0;
    logic              busy;
    logic [31:0]       tpc_next;
    logic              q_req = 1'b0;
    logic [31:0]       q_spc = '0;
    logic [31:0]       q_branch_tpc = '0;
    logic              q_ready;
    logic              q_valid;
    logic [31:0]       q_tpc;
    logic [31:0]       q_offset;

    int compared = 0;
    int mismatched = 0;
    logic [31:0] mem [64];
    int exp_n [64];
    int fetch_cnt = 0;
    int exp_fidx = 0;
    bit fetch_bad = 1'b0;
    int unsigned seed = 32'h1234_5678;

    always #(CLK_P/2) clk = ~clk;

    amap_engine #(.IDX_W(IDX_W)) dut (.*);

    // source buffer model: one-cycle read latency
    always @(posedge clk) begin
        if (start) begin
            fetch_cnt <= 0;
            exp_fidx  <= 0;
            fetch_bad <= 1'b0;
        end else if (fetch_en) begin
            fetch_word <= mem[fetch_idx[5:0]];
            if (int'(fetch_idx) != exp_fidx) fetch_bad <= 1'b1;
            exp_fidx  <= exp_fidx + 1;
            fetch_cnt <= fetch_cnt + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int nxt();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return int'(seed >> 8);
    endfunction

    function automatic int imm_extra(input logic [31:0] v);
        int sv = int'(v);
        if (sv >= -2048 && sv <= 2047) return 0;
        if ((v & 32'hfff) == 0) return 1;
        return 2;
    endfunction

    // expansion count from R4..R7
    function automatic int exp_count(input logic [31:0] w, input logic [31:0] m);
        int op = int'(w[31:26]);
        int fn = int'(w[5:0]);
        int rs = int'(w[25:21]);
        int rt = int'(w[20:16]);
        int dr = rt;
        int n = 3;
        bit sa = 0, sb = 0, de = 0;
        logic [31:0] sx = {{16{w[15]}}, w[15:0]};
        if (op == 0) begin
            dr = int'(w[15:11]);
            if (fn == 0 || fn == 2 || fn == 3) begin n = 1; sb = 1; de = 1; end
            else if (fn == 4 || fn == 6 || fn == 7 || (fn >= 32 && fn <= 39) || fn == 42 || fn == 43) begin
                n = 1; sa = 1; sb = 1; de = 1;
            end
        end else if (op == 1 || op == 6 || op == 7) begin n = 1; sa = 1; end
        else if (op == 4 || op == 5) begin n = 1; sa = 1; sb = 1; end
        else if (op == 2 || op == 3) n = 1;
        else if (op >= 8 && op <= 11) begin n = 1 + imm_extra(sx); sa = 1; de = 1; end
        else if (op >= 12 && op <= 14) begin n = 1 + imm_extra({16'b0, w[15:0]}); sa = 1; de = 1; end
        else if (op == 15) begin n = 1; de = 1; end
        else if (op == 32 || op == 33 || op == 35 || op == 36 || op == 37) begin
            n = 1 + ((imm_extra(sx) == 0) ? 0 : 2); sa = 1; de = 1;
        end else if (op == 40 || op == 41 || op == 43) begin
            n = 1 + ((imm_extra(sx) == 0) ? 0 : 2); sa = 1; sb = 1;
        end
        if (sa && rs != 0 && m[rs]) n++;
        if (sb && rt != 0 && m[rt] && !(sa && rs == rt)) n++;
        if (de && dr != 0 && m[dr]) n++;
        return n;
    endfunction

    task automatic query(input logic [31:0] spc, input logic [31:0] self,
                         output logic [31:0] tpc, output logic [31:0] off, output int stalls);
        stalls = 0;
        q_spc = spc;
        q_branch_tpc = self;
        q_req = 1'b1;
        #1;
        while (!q_ready && stalls < 2000) begin
            @(negedge clk); #1;
            stalls++;
        end
        @(negedge clk); #1;
        check("R9 valid", {31'b0, q_valid}, 32'd1);
        tpc = q_tpc;
        off = q_offset;
        q_req = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic verify_run(input int len, input logic [31:0] sb, input logic [31:0] tb, input string tag);
        logic [31:0] acc, got, off;
        int st;
        while (busy) @(negedge clk);
        acc = tb;
        for (int k = 0; k < len; k++) begin
            query(sb + 32'(4 * k), tb + 32'h40, got, off, st);
            check({"R3 entry ", tag}, got, acc);
            check({"R9 offset ", tag}, off, acc - (tb + 32'h40));
            acc = acc + 32'(4 * exp_n[k]);
        end
        check({"R3 end tpc ", tag}, tpc_next, acc);
        check({"R2 fetch count ", tag}, 32'(fetch_cnt), 32'(len));
        check({"R2 fetch order ", tag}, {31'b0, fetch_bad}, 32'd0);
    endtask

    task automatic gen_reg(output logic [4:0] r);
        int x = nxt();
        r = ((x % 11) == 10) ? 5'd0 : 5'(20 + (x % 10));
    endtask

    task automatic fill_random(input int len, input logic [31:0] m);
        logic [4:0] a, b, d;
        logic [15:0] imm;
        for (int k = 0; k < len; k++) begin
            int t = nxt() % 12;
            int x = nxt();
            gen_reg(a); gen_reg(b); gen_reg(d);
            imm = (x & 1) ? 16'((x >> 3) & 32'h0fff) : 16'(x >> 5);
            case (t)
                0: mem[k] = {6'h00, a, b, d, 5'd0, 6'h21};
                1: mem[k] = {6'h00, 5'd0, b, d, 5'(x), 6'h03};
                2: mem[k] = {6'h09, a, b, imm};
                3: mem[k] = {6'h0d, a, b, imm};
                4: mem[k] = {6'h0a, a, b, (x & 2) ? 16'h8000 : imm};
                5: mem[k] = {6'h23, a, b, imm};
                6: mem[k] = {6'h29, a, b, imm};
                7: mem[k] = {6'h05, a, b, imm};
                8: mem[k] = {6'h03, 26'(x)};
                9: mem[k] = {6'h00, a, 15'd0, 6'h09};
                10: mem[k] = {6'h3b, 26'(x)};
                default: mem[k] = {6'h0f, 5'd0, b, imm};
            endcase
            exp_n[k] = exp_count(mem[k], m);
        end
    endtask

    initial begin
        logic [31:0] got, off;
        int st;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        q_req = 1'b1;
        #1;
        check("R1 busy", {31'b0, busy}, 32'd0);
        check("R1 fetch_en", {31'b0, fetch_en}, 32'd0);
        check("R1 q_ready", {31'b0, q_ready}, 32'd0);
        check("R1 q_valid", {31'b0, q_valid}, 32'd0);
        q_req = 1'b0;

        // directed program: boundary immediates and reallocation (R4..R7)
        mem[0]  = 32'h033ac020; exp_n[0]  = 4; // R7 add 24,25,26 all reallocated
        mem[1]  = 32'h20217fff; exp_n[1]  = 3; // R5 addi 0x7fff
        mem[2]  = 32'h28628000; exp_n[2]  = 2; // R5 slti 0x8000, low bits zero
        mem[3]  = 32'h30217fff; exp_n[3]  = 3; // R5 andi 0x7fff
        mem[4]  = 32'h34628000; exp_n[4]  = 2; // R5 ori zero-extended 0x8000
        mem[5]  = 32'h8c627ffc; exp_n[5]  = 3; // R6 lw large
        mem[6]  = 32'hac248000; exp_n[6]  = 3; // R6 sw large negative
        mem[7]  = 32'h03e00008; exp_n[7]  = 3; // R4 register jump
        mem[8]  = 32'h1022ffff; exp_n[8]  = 1; // R4 branch
        mem[9]  = 32'h23380005; exp_n[9]  = 3; // R7 fill 25, spill 24
        mem[10] = 32'h13390000; exp_n[10] = 2; // R7 same source twice counted once
        mem[11] = 32'hfc000000; exp_n[11] = 3; // R4 unknown opcode
        mem[12] = 32'h00000001; exp_n[12] = 3; // R4 unknown funct
        mem[13] = 32'h2021f800; exp_n[13] = 1; // R5 -2048 fits
        mem[14] = 32'h20210800; exp_n[14] = 3; // R5 2048 does not fit
        mem[15] = 32'h20211000; exp_n[15] = 2; // R5 0x1000 low bits zero
        mem[16] = 32'h8c62f800; exp_n[16] = 1; // R6 -2048 fits
        mem[17] = 32'h0019c080; exp_n[17] = 3; // R7 shift: rt source only
        mem[18] = 32'h03000020; exp_n[18] = 2; // R7 register 0 never counts
        mem[19] = 32'h08000010; exp_n[19] = 1; // R4 jump
        mem[20] = 32'h3c181234; exp_n[20] = 2; // R7 upper immediate into reallocated
        mem[21] = 32'h00000000; exp_n[21] = 1; // R4 shift of zero registers
        spc_base = 32'hbfc00000;
        tpc_base = 32'hc0000000;
        src_len = 13'd22;
        realloc_mask = 32'h0700_0000;
        pulse_start();
        verify_run(22, spc_base, tpc_base, "directed");

        // R8: slot beyond the scanned length never becomes ready
        q_spc = spc_base + 32'd120;
        q_req = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk); #1;
            check("R8 unwritten slot ready", {31'b0, q_ready}, 32'd0);
            check("R8 unwritten slot valid", {31'b0, q_valid}, 32'd0);
        end
        q_req = 1'b0;

        // R2: zero-length scan fetches nothing, tpc stays at base
        src_len = '0;
        tpc_base = 32'h0000_2000;
        pulse_start();
        verify_run(0, spc_base, tpc_base, "empty");
        // R8: start cleared earlier entries
        q_spc = spc_base;
        q_req = 1'b1;
        #1;
        check("R8 cleared by start", {31'b0, q_ready}, 32'd0);
        q_req = 1'b0;

        // R10: lookup of the last slot issued right after start stalls
        realloc_mask = 32'h0f00_0000;
        fill_random(64, realloc_mask);
        src_len = 13'd64;
        spc_base = 32'h0040_0000;
        tpc_base = 32'h8000_0000;
        pulse_start();
        query(spc_base + 32'd252, tpc_base, got, off, st);
        begin
            int tot = 0;
            for (int k = 0; k < 63; k++) tot += exp_n[k];
            check("R10 stalled", {31'b0, (st > 0)}, 32'd1);
            check("R10 value", got, tpc_base + 32'(4 * tot));
            check("R10 offset", off, 32'(4 * tot));
        end
        verify_run(64, spc_base, tpc_base, "midscan");

        // sweeps over register masks and programs (R3..R7)
        for (int r = 0; r < 12; r++) begin
            realloc_mask = (r % 3 == 0) ? 32'h0 : (32'(nxt()) & 32'h3ff0_0000) | 32'h1;
            fill_random(64, realloc_mask);
            src_len = 13'(40 + (r % 3) * 12);
            spc_base = 32'(nxt()) & 32'hffff_fffc;
            tpc_base = 32'(nxt()) & 32'h7fff_fffc;
            pulse_start();
            verify_run(40 + (r % 3) * 12, spc_base, tpc_base, "sweep");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule